// File: doc/BRIEF.md
# Sixteen-Pin Two-Port Expander Register Bank

This block is the register-mapped core of a sixteen-pin I/O expander with two eight-pin ports. A byte-wide register interface sits in front of it, for example the back end of a serial bus target. That interface writes an address and data with `wr_en` and requests a read with `rd_en`. Every pin has four per-port registers: output level, direction, interrupt disable and function mode. Each register kind has its two ports at an even/odd address pair. A global control register, a fixed identification register and a soft-reset address complete the map.

Toward the pads the block produces a per-pin output enable and output level, and it exports the interrupt-disable bits and the alternate-function select. Pin n belongs to port n>>3 at bit n mod 8. Port 0 pins can drive open-drain or push-pull. Port 1 pins always drive push-pull.

Top module: `gpx_regbank`

## Requirements
- R1: After reset, output registers (0x02/0x03) read 0x00, direction (0x04/0x05) 0xFF, interrupt disable (0x06/0x07) 0x00, mode (0x12/0x13) 0xFF, global control (0x11) 0x00, and every pad output enable is low.
- R2: A write to 0x02–0x07, 0x11, 0x12 or 0x13 stores the byte, and a read of that address returns it. `rdata` updates on the clock edge where `rd_en` is high and holds otherwise. The even address of each pair holds port 0.
- R3: A read of 0x00 returns `pin_in[7:0]` and a read of 0x01 returns `pin_in[15:8]`, sampled at the read edge.
- R4: Address 0x10 reads 0x23, and writes to it are ignored.
- R5: Addresses 0x08–0x0F and 0x14–0x7E read 0x00, and writes to them change no register.
- R6: A pin whose direction bit is 1 is an input, and its `pad_oe` is low.
- R7: A port 1 pin with direction bit 0 drives push-pull: `pad_oe` high and `pad_out` equal to its output bit.
- R8: When bit 4 of global control is 1, port 0 output pins drive push-pull like R7.
- R9: When bit 4 of global control is 0, port 0 output pins are open-drain. An output bit of 1 gives `pad_oe` low. An output bit of 0 gives `pad_oe` high. `pad_out` is 0 in both cases.
- R10: A write of 0x00 to 0x7F returns every register to its R1 value on the next cycle. A write of any other value there has no effect. Reads of 0x7F return 0x00.
- R11: `irq_dis` equals the two interrupt-disable registers and `led_sel` is the inverse of the two mode registers, with port 0 in bits 7:0.
- R12: Writes to the input addresses 0x00/0x01 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe; `rdata` loads on this edge |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Live pad levels |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output level |
| irq_dis | output | 16 | Per-pin interrupt disable bits |
| led_sel | output | 16 | Per-pin alternate (LED/PWM) function select |

## Verification
A register write takes effect on the clock edge that accepts it. Pad enables, pad levels, `irq_dis` and `led_sel` follow from the registers through logic alone, so they are valid one edge after the write. The bench drives every input on the falling edge and inspects these outputs on the next falling edge. A read loads `rdata` on the edge where `rd_en` is high. The bench deasserts `rd_en` on the following falling edge and compares `rdata` there against its model, with `pin_in` held steady across the read.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int PORT_W = 8;
  localparam int NPORTS = 2;
  localparam int NPINS  = PORT_W * NPORTS;

  localparam logic [7:0] A_IN0   = 8'h00;
  localparam logic [7:0] A_OUT0  = 8'h02;
  localparam logic [7:0] A_DIR0  = 8'h04;
  localparam logic [7:0] A_IRQ0  = 8'h06;
  localparam logic [7:0] A_ID    = 8'h10;
  localparam logic [7:0] A_CTL   = 8'h11;
  localparam logic [7:0] A_MODE0 = 8'h12;
  localparam logic [7:0] A_SRST  = 8'h7F;
  localparam int         CTL_PP_BIT = 4;

  typedef enum logic [3:0] {
    K_IN, K_OUT, K_DIR, K_IRQ, K_ID, K_CTL, K_MODE, K_SRST, K_HOLE
  } kind_e;

  function automatic kind_e addr_kind(input logic [7:0] a);
    if (a[7:1] == A_IN0[7:1])        return K_IN;
    else if (a[7:1] == A_OUT0[7:1])  return K_OUT;
    else if (a[7:1] == A_DIR0[7:1])  return K_DIR;
    else if (a[7:1] == A_IRQ0[7:1])  return K_IRQ;
    else if (a == A_ID)              return K_ID;
    else if (a == A_CTL)             return K_CTL;
    else if (a[7:1] == A_MODE0[7:1]) return K_MODE;
    else if (a == A_SRST)            return K_SRST;
    else                             return K_HOLE;
  endfunction

  // Returns {oe, level} for one pin.
  function automatic logic [1:0] pin_drive(input logic is_in, input logic lvl,
                                           input logic od);
    if (is_in)   return 2'b00;
    else if (od) return {~lvl, 1'b0};
    else         return {1'b1, lvl};
  endfunction
endpackage

// File: rtl/gpx_decode.sv
module gpx_decode
  import gpx_pkg::*;
(
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  output kind_e             kind,
  output logic              port_sel,
  output logic [NPORTS-1:0] we_out,
  output logic [NPORTS-1:0] we_dir,
  output logic [NPORTS-1:0] we_irq,
  output logic [NPORTS-1:0] we_mode,
  output logic              we_ctl,
  output logic              soft_rst
);
  assign kind     = addr_kind(addr);
  assign port_sel = addr[0];
  assign we_ctl   = wr_en && (kind == K_CTL);
  assign soft_rst = wr_en && (kind == K_SRST) && (wdata == 8'h00);

  for (genvar p = 0; p < NPORTS; p++) begin : g_we
    localparam logic PSEL = p[0];
    assign we_out[p]  = wr_en && (kind == K_OUT)  && (port_sel == PSEL);
    assign we_dir[p]  = wr_en && (kind == K_DIR)  && (port_sel == PSEL);
    assign we_irq[p]  = wr_en && (kind == K_IRQ)  && (port_sel == PSEL);
    assign we_mode[p] = wr_en && (kind == K_MODE) && (port_sel == PSEL);
  end
endmodule

// File: rtl/gpx_port_regs.sv
module gpx_port_regs
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              we_out,
  input  logic              we_dir,
  input  logic              we_irq,
  input  logic              we_mode,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] out_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] irq_q,
  output logic [PORT_W-1:0] mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0; dir_q <= '1; irq_q <= '0; mode_q <= '1;
    end else if (soft_rst) begin
      out_q <= '0; dir_q <= '1; irq_q <= '0; mode_q <= '1;
    end else begin
      if (we_out)  out_q  <= wdata;
      if (we_dir)  dir_q  <= wdata;
      if (we_irq)  irq_q  <= wdata;
      if (we_mode) mode_q <= wdata;
    end
  end

  // R10: soft reset restores defaults one cycle later
  p_soft_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (out_q == '0 && dir_q == '1 && irq_q == '0 && mode_q == '1));
endmodule

// File: rtl/gpx_pad_ctrl.sv
module gpx_pad_ctrl
  import gpx_pkg::*;
#(
  parameter bit OD_CAPABLE = 1'b0
) (
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] out_q,
  input  logic              pp_sel,
  output logic [PORT_W-1:0] oe,
  output logic [PORT_W-1:0] lvl
);
  logic od_mode;
  if (OD_CAPABLE) begin : g_od
    assign od_mode = ~pp_sel;
  end else begin : g_pp
    assign od_mode = 1'b0;
    logic unused_pp;
    assign unused_pp = pp_sel;
  end

  for (genvar b = 0; b < PORT_W; b++) begin : g_pin
    logic [1:0] drv;
    assign drv    = pin_drive(dir_q[b], out_q[b], od_mode);
    assign oe[b]  = drv[1];
    assign lvl[b] = drv[0];
  end
endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
  import gpx_pkg::*;
#(
  parameter logic [7:0] ID_CODE = 8'h23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] irq_dis,
  output logic [NPINS-1:0] led_sel
);
  kind_e             kind;
  logic              port_sel;
  logic [NPORTS-1:0] we_out, we_dir, we_irq, we_mode;
  logic              we_ctl, soft_rst;

  gpx_decode u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .kind(kind), .port_sel(port_sel),
    .we_out(we_out), .we_dir(we_dir), .we_irq(we_irq), .we_mode(we_mode),
    .we_ctl(we_ctl), .soft_rst(soft_rst)
  );

  logic [7:0] ctl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_q <= 8'h00;
    else if (soft_rst) ctl_q <= 8'h00;
    else if (we_ctl)   ctl_q <= wdata;
  end

  logic [NPORTS-1:0][PORT_W-1:0] out_all, dir_all, irq_all, mode_all, in_all;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    gpx_port_regs u_regs (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .we_out(we_out[p]), .we_dir(we_dir[p]), .we_irq(we_irq[p]), .we_mode(we_mode[p]),
      .wdata(wdata), .out_q(out_all[p]), .dir_q(dir_all[p]),
      .irq_q(irq_all[p]), .mode_q(mode_all[p])
    );
    gpx_pad_ctrl #(.OD_CAPABLE(p == 0)) u_pad (
      .dir_q(dir_all[p]), .out_q(out_all[p]), .pp_sel(ctl_q[CTL_PP_BIT]),
      .oe(pad_oe[p*PORT_W +: PORT_W]), .lvl(pad_out[p*PORT_W +: PORT_W])
    );
    assign in_all[p]                    = pin_in[p*PORT_W +: PORT_W];
    assign irq_dis[p*PORT_W +: PORT_W]  = irq_all[p];
    assign led_sel[p*PORT_W +: PORT_W]  = ~mode_all[p];
  end

  logic [7:0] rd_mux;
  always_comb begin
    case (kind)
      K_IN:    rd_mux = in_all[port_sel];
      K_OUT:   rd_mux = out_all[port_sel];
      K_DIR:   rd_mux = dir_all[port_sel];
      K_IRQ:   rd_mux = irq_all[port_sel];
      K_MODE:  rd_mux = mode_all[port_sel];
      K_ID:    rd_mux = ID_CODE;
      K_CTL:   rd_mux = ctl_q;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= rd_mux;
  end

  // Named views for the assertions
  logic hole_wr, ro_wr;
  logic [4*NPINS+7:0] state_vec;
  assign hole_wr   = wr_en && (kind == K_HOLE);
  assign ro_wr     = wr_en && (kind == K_IN || kind == K_ID);
  assign state_vec = {out_all, dir_all, irq_all, mode_all, ctl_q};

  p_id_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_ID) |=> rdata == ID_CODE);
  p_hole_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && kind == K_HOLE) |=> rdata == 8'h00);
  p_hole_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hole_wr |=> $stable(state_vec));
  p_ro_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ro_wr |=> $stable(state_vec));
  p_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_IN0) |=> rdata == $past(pin_in[PORT_W-1:0]));
endmodule

// File: tb/gpx_regbank_tb.sv
module gpx_regbank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = 8'h00, wdata = 8'h00;
  logic [7:0]  rdata;
  logic [15:0] pin_in = 16'h0000;
  logic [15:0] pad_oe, pad_out, irq_dis, led_sel;

  int n_checks = 0, n_errors = 0;

  gpx_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .irq_dis(irq_dis), .led_sel(led_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model
  logic [7:0] m_out[2], m_dir[2], m_irq[2], m_mode[2], m_ctl;

  task automatic model_reset();
    for (int p = 0; p < 2; p++) begin
      m_out[p] = 8'h00; m_dir[p] = 8'hFF; m_irq[p] = 8'h00; m_mode[p] = 8'hFF;
    end
    m_ctl = 8'h00;
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h02, 8'h03: m_out[a[0]]  = d;
      8'h04, 8'h05: m_dir[a[0]]  = d;
      8'h06, 8'h07: m_irq[a[0]]  = d;
      8'h12, 8'h13: m_mode[a[0]] = d;
      8'h11:        m_ctl        = d;
      8'h7F:        if (d == 8'h00) model_reset();
      default: ;
    endcase
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [15:0] pins);
    case (a)
      8'h00:        return pins[7:0];
      8'h01:        return pins[15:8];
      8'h02, 8'h03: return m_out[a[0]];
      8'h04, 8'h05: return m_dir[a[0]];
      8'h06, 8'h07: return m_irq[a[0]];
      8'h10:        return 8'h23;
      8'h11:        return m_ctl;
      8'h12, 8'h13: return m_mode[a[0]];
      default:      return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    if (a <= 8'h01) return "R3";
    if (a == 8'h10) return "R4";
    if (a == 8'h7F) return "R10";
    if ((a >= 8'h08 && a <= 8'h0F) || (a >= 8'h14)) return "R5";
    return "R2";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); model_write(a, d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a);
    logic [7:0] e;
    @(negedge clk); rd_en = 1'b1; addr = a;
    e = exp_read(a, pin_in);
    @(negedge clk); rd_en = 1'b0;
    chk(rdata == e, read_tag(a), {8'h00, rdata}, {8'h00, e});
  endtask

  // Checks pad drive and exported masks against the model (at a falling edge).
  task automatic chk_pads();
    logic [15:0] eoe, eout;
    for (int n = 0; n < 16; n++) begin
      int p; int b;
      p = n / 8; b = n % 8;
      if (m_dir[p][b]) begin eoe[n] = 1'b0; eout[n] = 1'b0; end
      else if (p == 0 && !m_ctl[4]) begin eoe[n] = ~m_out[0][b]; eout[n] = 1'b0; end
      else begin eoe[n] = 1'b1; eout[n] = m_out[p][b]; end
    end
    chk({pad_oe[15:8], pad_out[15:8]} == {eoe[15:8], eout[15:8]}, "R7 port1 oe/out",
        {pad_oe[15:8], pad_out[15:8]}, {eoe[15:8], eout[15:8]});
    chk({pad_oe[7:0], pad_out[7:0]} == {eoe[7:0], eout[7:0]},
        m_ctl[4] ? "R8 port0 oe/out" : "R9 port0 oe/out",
        {pad_oe[7:0], pad_out[7:0]}, {eoe[7:0], eout[7:0]});
    chk(irq_dis == {m_irq[1], m_irq[0]}, "R11 irq_dis", irq_dis, {m_irq[1], m_irq[0]});
    chk(led_sel == ~{m_mode[1], m_mode[0]}, "R11 led_sel", led_sel, ~{m_mode[1], m_mode[0]});
  endtask

  function automatic logic [7:0] pick_addr(input int unsigned r);
    case (r % 14)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h02; 3: return 8'h03;
      4: return 8'h04; 5: return 8'h05; 6: return 8'h06; 7: return 8'h07;
      8: return 8'h10; 9: return 8'h11; 10: return 8'h12; 11: return 8'h13;
      12: return 8'h08 + 8'((r >> 4) % 8);
      default: return 8'h14 + 8'((r >> 4) % 107);
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    chk(pad_oe == 16'h0000, "R1 pad_oe after reset", pad_oe, 16'h0000);
    foreach (pick_addr_list[i]) do_read(pick_addr_list[i]);
    chk_pads();

    // R6: all inputs even with outputs set
    do_write(8'h02, 8'hFF); do_write(8'h03, 8'hFF);
    chk(pad_oe == 16'h0000, "R6 inputs not driven", pad_oe, 16'h0000);

    // R9 then R8 on port 0, R7 on port 1
    do_write(8'h04, 8'h00); do_write(8'h05, 8'h0F);
    do_write(8'h02, 8'hA5); do_write(8'h03, 8'h3C);
    chk(pad_oe[7:0] == 8'h5A && pad_out[7:0] == 8'h00, "R9 open-drain",
        {pad_oe[7:0], pad_out[7:0]}, 16'h5A00);
    chk_pads();
    do_write(8'h11, 8'h10);
    chk(pad_oe[7:0] == 8'hFF && pad_out[7:0] == 8'hA5, "R8 push-pull",
        {pad_oe[7:0], pad_out[7:0]}, 16'hFFA5);
    chk(pad_oe[15:8] == 8'hF0 && pad_out[15:8] == 8'h30, "R7 port1",
        {pad_oe[15:8], pad_out[15:8]}, 16'hF030);
    do_write(8'h11, 8'h00);
    chk(pad_oe[15:8] == 8'hF0, "R7 port1 ignores control bit", {8'h00, pad_oe[15:8]}, 16'h00F0);

    // R3: live input reads
    pin_in = 16'hBE71; do_read(8'h00); do_read(8'h01);

    // R4, R12, R5: ignored writes
    do_write(8'h10, 8'h55); do_read(8'h10);
    do_write(8'h00, 8'h99); do_write(8'h01, 8'h66); do_read(8'h02); do_read(8'h03);
    chk_pads();
    do_write(8'h09, 8'hFF); do_write(8'h40, 8'hFF); do_read(8'h09); do_read(8'h40);
    chk_pads();

    // R10: nonzero write ignored, zero write resets
    do_write(8'h7F, 8'h01);
    chk(pad_oe[7:0] == 8'h5A, "R10 nonzero soft reset ignored", {8'h00, pad_oe[7:0]}, 16'h005A);
    do_read(8'h7F);
    do_write(8'h7F, 8'h00);
    chk(pad_oe == 16'h0000, "R10 soft reset pads", pad_oe, 16'h0000);
    do_read(8'h04); do_read(8'h13); do_read(8'h11);
    chk_pads();

    // Constrained random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned r;
      logic [7:0] a;
      r = $urandom;
      pin_in = 16'($urandom);
      a = pick_addr(r >> 3);
      if (r % 29 == 0)      do_write(8'h7F, (r % 2 == 0) ? 8'h00 : 8'h80);
      else if (r % 2 == 0)  do_write(a, 8'($urandom));
      else                  do_read(a);
      chk_pads();
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  logic [7:0] pick_addr_list[8] = '{8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h11, 8'h12};
endmodule